// File: doc/BRIEF.md
# Credit-Flow Stream Port

This block sits between a streaming accelerator and a ring interconnect. It moves samples both ways.

On the outbound path, the accelerator offers samples with a valid/ready handshake. The port forwards each accepted sample to the ring as a posted write to a fixed destination address. It only accepts a sample while it holds a send credit. The credit counter starts at the depth of the far receiver's buffer. It loses one per sample sent and gains one per credit pulse arriving on a separate return channel, so the far buffer can never overflow.

On the inbound path, ring writes addressed to this port are stripped of their address and queued in a shallow receive FIFO. The accelerator drains the FIFO through a valid/ready handshake. For every sample the accelerator takes, one credit pulse goes back on the return channel, which runs opposite to the data. Nothing stalls the data ring itself: the credit scheme guarantees that the receive buffer always has room for what the sender is allowed to send.

Top module: `scp_stream_port`

## Requirements
- R1: After reset, the following hold:
  - the send credit count equals `TX_CREDITS`, so `acc_tx_ready` is 1;
  - `ring_tx_valid`, `acc_rx_valid` and `crd_out_valid` are 0.
- R2: A sample accepted on the accelerator send handshake appears on the ring in the next cycle:
  - `ring_tx_valid` is 1;
  - `ring_tx_data` carries the same value;
  - `ring_tx_addr` equals `DEST_ADDR`.
- R3: Each accepted sample uses one credit. `acc_tx_ready` is 0 exactly while the credit count is zero, so at most `TX_CREDITS` samples go out without a credit return.
- R4: Each cycle with `crd_in_valid` high adds one credit. The count saturates at `TX_CREDITS`, and extra returns have no effect.
- R5: A cycle with both an accepted sample and a credit return leaves the credit count unchanged.
- R6: A ring write with `ring_rx_addr` equal to `LOCAL_ADDR` is queued. It is visible on `acc_rx_valid`/`acc_rx_data` in the next cycle if the FIFO was empty.
- R7: Ring writes to any other address are ignored and never reach the accelerator.
- R8: The receive FIFO behaves as follows:
  - it holds up to `RX_DEPTH` samples and delivers them in arrival order;
  - `acc_rx_valid` is 1 while it is non-empty;
  - a write arriving while the FIFO is full is accepted only if a sample leaves in the same cycle.
- R9: `crd_out_valid` is 1 for one cycle, one cycle after each sample consumed by the accelerator, and at no other time. Arrivals produce no credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_tx_valid | input | 1 | Accelerator offers an outbound sample |
| acc_tx_data | input | DATA_W | Outbound sample |
| acc_tx_ready | output | 1 | Port holds a credit and accepts the sample |
| ring_tx_valid | output | 1 | Posted write onto the data ring |
| ring_tx_addr | output | ADDR_W | Destination address of the write |
| ring_tx_data | output | DATA_W | Write payload |
| crd_in_valid | input | 1 | One credit returned from the far receiver |
| ring_rx_valid | input | 1 | Incoming ring write |
| ring_rx_addr | input | ADDR_W | Address of the incoming write |
| ring_rx_data | input | DATA_W | Payload of the incoming write |
| acc_rx_valid | output | 1 | Inbound sample available to the accelerator |
| acc_rx_data | output | DATA_W | Inbound sample at the FIFO head |
| acc_rx_ready | input | 1 | Accelerator takes the inbound sample |
| crd_out_valid | output | 1 | One credit sent back to the upstream sender |

## Verification
Every cycle, the assertions check the credit arithmetic:
- a send alone removes one credit;
- a send with a return keeps the count;
- a return at the limit keeps it at the limit;
- the count never exceeds its reset value.

They also check that each outbound handshake is followed by a ring write with the same payload, that each consumed sample is followed by a credit pulse, and that no write lands in a full FIFO without a pop.

Only the bench scenarios can show the following:
- ordering through the FIFO;
- address filtering;
- the exact cycle at which sending stalls after saturation;
- that a write arriving during a simultaneous pop on a full FIFO keeps its place.

// File: rtl/scp_pkg.sv
package scp_pkg;

    // Credit event encoding: bit 1 = credit returned, bit 0 = sample spent
    typedef enum logic [1:0] {
        CRD_IDLE   = 2'b00,
        CRD_SPEND  = 2'b01,
        CRD_REFILL = 2'b10,
        CRD_SWAP   = 2'b11
    } crd_evt_e;

    localparam int unsigned DEF_DATA_W  = 32;
    localparam int unsigned DEF_ADDR_W  = 16;
    localparam int unsigned DEF_DEPTH   = 2;

endpackage

// File: rtl/scp_tx_credit.sv
module scp_tx_credit
    import scp_pkg::*;
#(
    parameter int unsigned          CREDITS   = DEF_DEPTH,
    parameter int unsigned          DATA_W    = DEF_DATA_W,
    parameter int unsigned          ADDR_W    = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0]    DEST_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              crd_in,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);

    localparam int unsigned  CW   = $clog2(CREDITS + 1);
    localparam logic [CW-1:0] FULL = CW'(CREDITS);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic              vld;
        logic [DATA_W-1:0] data;
    } tx_st_t;

    tx_st_t   st_d, st_q;
    logic     fire;
    crd_evt_e evt;

    always_comb begin
        st_d = st_q;
        fire = in_valid && (st_q.cnt != '0);
        evt  = crd_evt_e'({crd_in, fire});
        case (evt)
            CRD_SPEND:  st_d.cnt = st_q.cnt - 1'b1;
            CRD_REFILL: if (st_q.cnt != FULL) st_d.cnt = st_q.cnt + 1'b1;
            default:    st_d.cnt = st_q.cnt;
        endcase
        st_d.vld = fire;
        if (fire) st_d.data = in_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: FULL, vld: 1'b0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = (st_q.cnt != '0);
    assign out_valid = st_q.vld;
    assign out_addr  = DEST_ADDR;
    assign out_data  = st_q.data;

    AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL) else $error("credit count above limit"); // R4

    AST_SPEND_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !crd_in) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1))
        else $error("send did not use one credit"); // R3

    AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && crd_in) |=> $stable(st_q.cnt))
        else $error("send with return changed count"); // R5

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (crd_in && !in_valid && st_q.cnt == FULL) |=> (st_q.cnt == FULL))
        else $error("credit count wrapped"); // R4

endmodule

// File: rtl/scp_rx_fifo.sv
module scp_rx_fifo
    import scp_pkg::*;
#(
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic              crd_out
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PW-1:0]                wr_ptr;
        logic [PW-1:0]                rd_ptr;
        logic [CW-1:0]                cnt;
        logic                         crd;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   pop, full, take;

    always_comb begin
        st_d = st_q;
        full = (st_q.cnt == FULL);
        pop  = (st_q.cnt != '0) && out_ready;
        take = push && (!full || pop);
        if (take) begin
            st_d.mem[st_q.wr_ptr] = push_data;
            st_d.wr_ptr = (st_q.wr_ptr == LAST) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({take, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        st_d.crd = pop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = (st_q.cnt != '0);
    assign out_data  = st_q.mem[st_q.rd_ptr];
    assign crd_out   = st_q.crd;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !out_ready)) else $error("write into full receive buffer"); // R8

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL) else $error("receive occupancy above depth"); // R8

endmodule

// File: rtl/scp_stream_port.sv
module scp_stream_port
    import scp_pkg::*;
#(
    parameter int unsigned       DATA_W     = DEF_DATA_W,
    parameter int unsigned       ADDR_W     = DEF_ADDR_W,
    parameter int unsigned       TX_CREDITS = DEF_DEPTH,
    parameter int unsigned       RX_DEPTH   = DEF_DEPTH,
    parameter logic [ADDR_W-1:0] LOCAL_ADDR = ADDR_W'(16'h0040),
    parameter logic [ADDR_W-1:0] DEST_ADDR  = ADDR_W'(16'h0080)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_tx_valid,
    input  logic [DATA_W-1:0] acc_tx_data,
    output logic              acc_tx_ready,
    output logic              ring_tx_valid,
    output logic [ADDR_W-1:0] ring_tx_addr,
    output logic [DATA_W-1:0] ring_tx_data,
    input  logic              crd_in_valid,
    input  logic              ring_rx_valid,
    input  logic [ADDR_W-1:0] ring_rx_addr,
    input  logic [DATA_W-1:0] ring_rx_data,
    output logic              acc_rx_valid,
    output logic [DATA_W-1:0] acc_rx_data,
    input  logic              acc_rx_ready,
    output logic              crd_out_valid
);

    logic rx_hit;

    assign rx_hit = ring_rx_valid && (ring_rx_addr == LOCAL_ADDR);

    scp_tx_credit #(
        .CREDITS   (TX_CREDITS),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .DEST_ADDR (DEST_ADDR)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (acc_tx_valid),
        .in_data   (acc_tx_data),
        .in_ready  (acc_tx_ready),
        .crd_in    (crd_in_valid),
        .out_valid (ring_tx_valid),
        .out_addr  (ring_tx_addr),
        .out_data  (ring_tx_data)
    );

    scp_rx_fifo #(
        .DEPTH  (RX_DEPTH),
        .DATA_W (DATA_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_hit),
        .push_data (ring_rx_data),
        .out_valid (acc_rx_valid),
        .out_data  (acc_rx_data),
        .out_ready (acc_rx_ready),
        .crd_out   (crd_out_valid)
    );

    AST_TX_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_tx_valid && acc_tx_ready) |=>
            (ring_tx_valid && ring_tx_data == $past(acc_tx_data) && ring_tx_addr == DEST_ADDR))
        else $error("accepted sample not forwarded"); // R2

    AST_NO_SPURIOUS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_tx_valid && acc_tx_ready) |=> !ring_tx_valid)
        else $error("ring write without handshake"); // R2

    AST_CREDIT_PER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rx_valid && acc_rx_ready) |=> crd_out_valid)
        else $error("consumed sample returned no credit"); // R9

    AST_NO_FREE_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_rx_valid && acc_rx_ready) |=> !crd_out_valid)
        else $error("credit without consumption"); // R9

    AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_rx_valid && ring_rx_addr != LOCAL_ADDR && !acc_rx_valid) |=> !acc_rx_valid)
        else $error("foreign write reached accelerator"); // R7

endmodule

// File: tb/scp_stream_port_bench.sv
module scp_stream_port_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          DATA_W     = 32;
    localparam int          ADDR_W     = 16;
    localparam int          TX_CREDITS = 2;
    localparam int          RX_DEPTH   = 2;
    localparam logic [15:0] LOCAL_ADDR = 16'h0040;
    localparam logic [15:0] DEST_ADDR  = 16'h0080;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_tx_valid = 1'b0;
    logic [DATA_W-1:0] acc_tx_data = '0;
    logic              acc_tx_ready;
    logic              ring_tx_valid;
    logic [ADDR_W-1:0] ring_tx_addr;
    logic [DATA_W-1:0] ring_tx_data;
    logic              crd_in_valid = 1'b0;
    logic              ring_rx_valid = 1'b0;
    logic [ADDR_W-1:0] ring_rx_addr = '0;
    logic [DATA_W-1:0] ring_rx_data = '0;
    logic              acc_rx_valid;
    logic [DATA_W-1:0] acc_rx_data;
    logic              acc_rx_ready = 1'b0;
    logic              crd_out_valid;

    int total = 0;
    int bad   = 0;

    // reference model state
    int                m_cred;
    bit                m_rv;
    logic [DATA_W-1:0] m_rd;
    bit                m_crd;
    logic [DATA_W-1:0] m_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    scp_stream_port #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TX_CREDITS(TX_CREDITS), .RX_DEPTH(RX_DEPTH),
        .LOCAL_ADDR(LOCAL_ADDR), .DEST_ADDR(DEST_ADDR)
    ) u_scp_stream_port (
        .clk(clk), .rst_n(rst_n),
        .acc_tx_valid(acc_tx_valid), .acc_tx_data(acc_tx_data), .acc_tx_ready(acc_tx_ready),
        .ring_tx_valid(ring_tx_valid), .ring_tx_addr(ring_tx_addr), .ring_tx_data(ring_tx_data),
        .crd_in_valid(crd_in_valid),
        .ring_rx_valid(ring_rx_valid), .ring_rx_addr(ring_rx_addr), .ring_rx_data(ring_rx_data),
        .acc_rx_valid(acc_rx_valid), .acc_rx_data(acc_rx_data), .acc_rx_ready(acc_rx_ready),
        .crd_out_valid(crd_out_valid)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cred = TX_CREDITS;
            m_rv   = 0;
            m_rd   = '0;
            m_crd  = 0;
            m_q.delete();
        end else begin
            bit fire, give, pop, push;
            fire = acc_tx_valid && (m_cred > 0);
            give = crd_in_valid;
            m_rv = fire;
            if (fire) m_rd = acc_tx_data;
            if (fire && !give) m_cred = m_cred - 1;
            else if (give && !fire && m_cred < TX_CREDITS) m_cred = m_cred + 1;
            pop  = (m_q.size() > 0) && acc_rx_ready;
            push = ring_rx_valid && (ring_rx_addr == LOCAL_ADDR);
            m_crd = pop;
            if (pop) void'(m_q.pop_front());
            if (push && m_q.size() < RX_DEPTH) m_q.push_back(ring_rx_data);
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(acc_tx_ready == (m_cred > 0), "R3 tx ready", acc_tx_ready, (m_cred > 0));
            check(ring_tx_valid == m_rv, "R2 ring valid", ring_tx_valid, m_rv);
            if (m_rv) begin
                check(ring_tx_data == m_rd, "R2 ring data", ring_tx_data, m_rd);
                check(ring_tx_addr == DEST_ADDR, "R2 ring addr", ring_tx_addr, DEST_ADDR);
            end
            check(acc_rx_valid == (m_q.size() > 0), "R8 rx valid", acc_rx_valid, (m_q.size() > 0));
            if (m_q.size() > 0)
                check(acc_rx_data == m_q[0], "R8 rx order", acc_rx_data, m_q[0]);
            check(crd_out_valid == m_crd, "R9 credit out", crd_out_valid, m_crd);
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        step(); step(); step();
        rst_n = 1'b1;
        @(negedge clk);
        check(acc_tx_ready == 1'b1, "R1 ready", acc_tx_ready, 1);
        check(ring_tx_valid == 1'b0, "R1 ring valid", ring_tx_valid, 0);
        check(acc_rx_valid == 1'b0, "R1 rx valid", acc_rx_valid, 0);
        check(crd_out_valid == 1'b0, "R1 credit out", crd_out_valid, 0);
        step();

        // send until credits run out
        acc_tx_valid = 1'b1; acc_tx_data = 32'hA0A0_0001; step();
        acc_tx_data = 32'hA0A0_0002; step();
        acc_tx_data = 32'hA0A0_0003; step();
        @(negedge clk);
        check(acc_tx_ready == 1'b0, "R3 stall at zero", acc_tx_ready, 0);
        step();
        acc_tx_valid = 1'b0;
        crd_in_valid = 1'b1; step();
        crd_in_valid = 1'b0;
        @(negedge clk);
        check(acc_tx_ready == 1'b1, "R4 credit return", acc_tx_ready, 1);
        step();

        // simultaneous send and return at count one
        acc_tx_valid = 1'b1; acc_tx_data = 32'hD00D_0004; crd_in_valid = 1'b1; step();
        acc_tx_valid = 1'b0; crd_in_valid = 1'b0;
        @(negedge clk);
        check(acc_tx_ready == 1'b1, "R5 swap keeps credit", acc_tx_ready, 1);
        step();

        // saturation: extra returns are ignored
        crd_in_valid = 1'b1;
        for (int i = 0; i < 4; i++) step();
        crd_in_valid = 1'b0;
        acc_tx_valid = 1'b1;
        for (int i = 0; i < TX_CREDITS; i++) begin
            acc_tx_data = 32'hE000_0000 + i;
            step();
        end
        @(negedge clk);
        check(acc_tx_ready == 1'b0, "R4 saturated at limit", acc_tx_ready, 0);
        step();
        acc_tx_valid = 1'b0;
        crd_in_valid = 1'b1; step(); step();
        crd_in_valid = 1'b0;

        // receive path
        ring_rx_valid = 1'b1; ring_rx_addr = LOCAL_ADDR + 16'd1; ring_rx_data = 32'hBAD0_0001; step();
        ring_rx_valid = 1'b0;
        @(negedge clk);
        check(acc_rx_valid == 1'b0, "R7 foreign write ignored", acc_rx_valid, 0);
        step();
        ring_rx_valid = 1'b1; ring_rx_addr = LOCAL_ADDR; ring_rx_data = 32'h0000_0011; step();
        ring_rx_data = 32'h0000_0022; step();
        ring_rx_valid = 1'b0;
        @(negedge clk);
        check(acc_rx_valid == 1'b1 && acc_rx_data == 32'h11, "R6 local write queued", acc_rx_data, 32'h11);
        check(crd_out_valid == 1'b0, "R9 no credit on arrival", crd_out_valid, 0);
        step();
        acc_rx_ready = 1'b1; step();
        acc_rx_ready = 1'b0;
        @(negedge clk);
        check(crd_out_valid == 1'b1, "R9 credit after pop", crd_out_valid, 1);
        check(acc_rx_data == 32'h22, "R8 second in order", acc_rx_data, 32'h22);
        step();
        ring_rx_valid = 1'b1; ring_rx_data = 32'h0000_0033; step();
        acc_rx_ready = 1'b1; ring_rx_data = 32'h0000_0044; step();
        acc_rx_ready = 1'b0; ring_rx_valid = 1'b0;
        @(negedge clk);
        check(acc_rx_data == 32'h33, "R8 push on full with pop", acc_rx_data, 32'h33);
        step();
        acc_rx_ready = 1'b1; step(); step();
        acc_rx_ready = 1'b0;
        @(negedge clk);
        check(acc_rx_valid == 1'b0, "R8 drained", acc_rx_valid, 0);
        step();

        // mixed traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            acc_tx_valid  = lfsr[0];
            acc_tx_data   = {lfsr, lfsr ^ 16'h5A5A};
            crd_in_valid  = lfsr[1] & lfsr[2];
            acc_rx_ready  = lfsr[3];
            ring_rx_valid = lfsr[4] && (m_q.size() < RX_DEPTH);
            ring_rx_addr  = lfsr[5] ? LOCAL_ADDR : (LOCAL_ADDR + 16'd3);
            ring_rx_data  = {lfsr ^ 16'h0F0F, lfsr};
            step();
        end
        acc_tx_valid = 1'b0; crd_in_valid = 1'b0; ring_rx_valid = 1'b0; acc_rx_ready = 1'b0;
        step(); step();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule